// File: doc/BRIEF.md
# Card Socket Power Sequencer

This block brings a removable card socket up and takes it down in a fixed order. It drives the supply selects, the two enable lines and the card reset, and it waits between steps. A one-cycle enable pulse starts power-up and a one-cycle disable pulse starts power-down. Every wait comes from one down-counter that steps on a microsecond tick. The tick comes from a prescaler over the system clock.

Power-up runs in this order:
- Card enable is turned off and the block waits a short settle time.
- Both supplies go to 0 V.
- The block waits for the supply to fall and for the off time.
- The requested Vcc is applied and the block waits for rise and settle.
- Both enables are raised and the block waits again.
- The card reset is pulsed.
- After a last wait the socket reports that it is powered.

Power-down turns card enable off first. It then removes both supplies and waits for the rail to fall. All waits are parameters in microsecond ticks, so a bench can shorten them.

Top module: `socket_pwr_seq`

## Requirements
- R1: After reset, `vcc_sel` and `vpp_sel` are 00 and `card_en`, `glob_en`, `card_rst`, `busy` and `powered` are all 0.
- R2: An `en_req` pulse is accepted when the socket is off, not busy, and `vcc_target` is 01 (3 V) or 10 (5 V). On the edge that samples the pulse, `busy` goes to 1 and `card_en` is 0. The Vcc code is latched on that edge.
- R3: An enable request with `vcc_target` = 11 is rejected. `busy` stays 0 and all outputs stay at their off values.
- R4: Each wait of N ticks lasts exactly N*CLK_PER_US+1 clock cycles. The latched Vcc code appears on `vcc_sel` after three waits: card-enable-off (T_CE_OFF), supply-zero (T_ZERO) and fall (T_FALL). `vcc_sel` never shows 11.
- R5: `glob_en` and `card_en` rise together one rise wait (T_RISE) after Vcc is applied.
- R6: `card_rst` rises one enable wait (T_ENABLE) after the enables rise. It stays high for exactly the T_RESET wait. It is never high unless both enables are high and Vcc is on.
- R7: `powered` rises and `busy` falls on the same cycle, one post-reset wait (T_POST) after `card_rst` falls. `powered` and `busy` are never both 1.
- R8: A `dis_req` pulse while powered does three things in order:
  - On the accepting edge it clears `card_en` and `powered` and raises `busy`.
  - After T_CE_OFF it sets `vcc_sel` and `glob_en` to 0.
  - After a further T_DN_FALL it drops `busy`.
- R9: `en_req` and `dis_req` have no effect while busy, including during the reset pulse. They also have no effect when they do not apply to the current state (enable while powered, disable while off).
- R10: `vpp_sel` is 00 (0 V) in every state. Once Vcc is applied it keeps the latched code, even when `vcc_target` changes, until power-down removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req | input | 1 | One-cycle power-up request |
| dis_req | input | 1 | One-cycle power-down request |
| vcc_target | input | 2 | Requested Vcc code: 01 = 3 V, 10 = 5 V, 11 = invalid |
| vcc_sel | output | 2 | Vcc switch select: 00 = 0 V, 01 = 3 V, 10 = 5 V |
| vpp_sel | output | 2 | Vpp switch select: 00 = 0 V, 01 = follow Vcc, 10 = 12 V, 11 = high impedance |
| card_en | output | 1 | Card interface enable |
| glob_en | output | 1 | Global output and interrupt enable |
| card_rst | output | 1 | Active-high card reset |
| busy | output | 1 | A power-up or power-down sequence is running |
| powered | output | 1 | The socket is fully powered and out of reset |

## Verification
The assertions take three things for granted:
- Requests are single-cycle pulses.
- `vcc_target` may change at any time.
- Every delay parameter is at least one tick.

The bench uses one-cycle pulses only. Stray pulses are placed at every cycle offset of the power-up and power-down sequences. During each run it swaps `vcc_target` to a different code, so both the ignore rule and the latching are exercised. Each phase boundary is then compared with the cycle count computed from N*CLK_PER_US+1.

// File: rtl/socket_pwr_seq_pkg.sv
package socket_pwr_seq_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_UP_CEOFF,
        S_UP_ZERO,
        S_UP_FALL,
        S_UP_VCC,
        S_UP_EN,
        S_UP_RST,
        S_UP_POST,
        S_ON,
        S_DN_CEOFF,
        S_DN_ZERO
    } seq_state_e;

    localparam logic [1:0] VCC_0V   = 2'b00;
    localparam logic [1:0] VCC_BAD  = 2'b11;
    localparam logic [1:0] VPP_0V   = 2'b00;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pwr_us_tick.sv
module pwr_us_tick #(
    parameter int CLK_PER_US = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        if (restart || pre_q == PRE_LAST) pre_d = '0;
        else                              pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick = !restart && (pre_q == PRE_LAST);

    p_pre_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);

endmodule

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                   cnt_d = load_val;
        else if (tick && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    p_cnt_nonincr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> cnt_q <= $past(cnt_q));

endmodule

// File: rtl/socket_pwr_seq.sv
module socket_pwr_seq
    import socket_pwr_seq_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int T_CE_OFF   = 20000,
    parameter int T_ZERO     = 20000,
    parameter int T_FALL     = 400000,
    parameter int T_RISE     = 420000,
    parameter int T_ENABLE   = 200000,
    parameter int T_RESET    = 10,
    parameter int T_POST     = 20000,
    parameter int T_DN_FALL  = 320000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       dis_req,
    input  logic [1:0] vcc_target,
    output logic [1:0] vcc_sel,
    output logic [1:0] vpp_sel,
    output logic       card_en,
    output logic       glob_en,
    output logic       card_rst,
    output logic       busy,
    output logic       powered
);
    localparam int T_MAX = max2(max2(max2(T_CE_OFF, T_ZERO), max2(T_FALL, T_RISE)),
                                max2(max2(T_ENABLE, T_RESET), max2(T_POST, T_DN_FALL)));
    localparam int CNT_W = $clog2(T_MAX + 1);

    localparam logic [CNT_W-1:0] L_CE_OFF  = CNT_W'(T_CE_OFF);
    localparam logic [CNT_W-1:0] L_ZERO    = CNT_W'(T_ZERO);
    localparam logic [CNT_W-1:0] L_FALL    = CNT_W'(T_FALL);
    localparam logic [CNT_W-1:0] L_RISE    = CNT_W'(T_RISE);
    localparam logic [CNT_W-1:0] L_ENABLE  = CNT_W'(T_ENABLE);
    localparam logic [CNT_W-1:0] L_RESET   = CNT_W'(T_RESET);
    localparam logic [CNT_W-1:0] L_POST    = CNT_W'(T_POST);
    localparam logic [CNT_W-1:0] L_DN_FALL = CNT_W'(T_DN_FALL);

    typedef struct packed {
        seq_state_e st;
        logic [1:0] tgt;
        logic [1:0] vcc;
        logic [1:0] vpp;
        logic       ce;
        logic       ge;
        logic       rst;
    } seq_regs_t;

    seq_regs_t        q, d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             tick;
    logic             expired;

    pwr_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ld),
        .tick    (tick)
    );

    pwr_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .tick     (tick),
        .expired  (expired)
    );

    always_comb begin
        d      = q;
        ld     = 1'b0;
        ld_val = '0;
        unique case (q.st)
            S_OFF: if (en_req && vcc_target != VCC_0V && vcc_target != VCC_BAD) begin
                d.st = S_UP_CEOFF; d.tgt = vcc_target; d.ce = 1'b0;
                ld = 1'b1; ld_val = L_CE_OFF;
            end
            S_UP_CEOFF: if (expired) begin
                d.st = S_UP_ZERO; d.vcc = VCC_0V; d.vpp = VPP_0V;
                ld = 1'b1; ld_val = L_ZERO;
            end
            S_UP_ZERO: if (expired) begin
                d.st = S_UP_FALL; ld = 1'b1; ld_val = L_FALL;
            end
            S_UP_FALL: if (expired) begin
                d.st = S_UP_VCC; d.vcc = q.tgt; d.vpp = VPP_0V;
                ld = 1'b1; ld_val = L_RISE;
            end
            S_UP_VCC: if (expired) begin
                d.st = S_UP_EN; d.ge = 1'b1; d.ce = 1'b1;
                ld = 1'b1; ld_val = L_ENABLE;
            end
            S_UP_EN: if (expired) begin
                d.st = S_UP_RST; d.rst = 1'b1; ld = 1'b1; ld_val = L_RESET;
            end
            S_UP_RST: if (expired) begin
                d.st = S_UP_POST; d.rst = 1'b0; ld = 1'b1; ld_val = L_POST;
            end
            S_UP_POST: if (expired) d.st = S_ON;
            S_ON: if (dis_req) begin
                d.st = S_DN_CEOFF; d.ce = 1'b0; ld = 1'b1; ld_val = L_CE_OFF;
            end
            S_DN_CEOFF: if (expired) begin
                d.st = S_DN_ZERO; d.vcc = VCC_0V; d.vpp = VPP_0V; d.ge = 1'b0;
                ld = 1'b1; ld_val = L_DN_FALL;
            end
            S_DN_ZERO: if (expired) d.st = S_OFF;
            default: d.st = S_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: S_OFF, tgt: VCC_0V, vcc: VCC_0V, vpp: VPP_0V,
                   ce: 1'b0, ge: 1'b0, rst: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign vcc_sel  = q.vcc;
    assign vpp_sel  = q.vpp;
    assign card_en  = q.ce;
    assign glob_en  = q.ge;
    assign card_rst = q.rst;
    assign powered  = (q.st == S_ON);
    assign busy     = (q.st != S_OFF) && (q.st != S_ON);

    p_vcc_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_sel != VCC_BAD);
    p_ce_needs_ge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        card_en |-> glob_en);
    p_rst_context_r6: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (card_en && glob_en && vcc_sel != VCC_0V));
    p_rst_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst) |=> card_rst);
    p_pwr_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(powered && busy));
    p_busy_by_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(en_req || dis_req));
    p_vpp_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_sel == VPP_0V);
    p_vcc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_sel != VCC_0V && $past(vcc_sel) != VCC_0V) |-> $stable(vcc_sel));

endmodule

// File: tb/tb_socket_pwr_seq.sv
module tb_socket_pwr_seq;
    localparam int P = 2;
    localparam int TCE = 3, TZ = 2, TF = 5, TR = 4, TEN = 3, TRS = 2, TPO = 3, TDN = 6;

    logic clk = 1'b0, rst_n = 1'b0, en_req = 1'b0, dis_req = 1'b0;
    logic [1:0] vcc_target = 2'b01;
    logic [1:0] vcc_sel, vpp_sel;
    logic card_en, glob_en, card_rst, busy, powered;
    int cyc = 0, checks = 0, errors = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    socket_pwr_seq #(.CLK_PER_US(P), .T_CE_OFF(TCE), .T_ZERO(TZ), .T_FALL(TF),
        .T_RISE(TR), .T_ENABLE(TEN), .T_RESET(TRS), .T_POST(TPO), .T_DN_FALL(TDN)) dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .vcc_target(vcc_target), .vcc_sel(vcc_sel), .vpp_sel(vpp_sel),
        .card_en(card_en), .glob_en(glob_en), .card_rst(card_rst),
        .busy(busy), .powered(powered));

    function automatic int dur(input int n);
        return n * P + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Power-up with a stray request (and a vcc_target swap) at offset inj.
    task automatic power_up(input logic [1:0] tgt, input int inj);
        int e, t_vcc, t_en, t_rr, t_rf, t_pw, t_bf, vcc_seen, vpp_bad, ce_at_en;
        t_vcc = -1; t_en = -1; t_rr = -1; t_rf = -1; t_pw = -1; t_bf = -1;
        vcc_seen = 0; vpp_bad = 0; ce_at_en = 0;
        @(negedge clk); vcc_target = tgt; en_req = 1'b1;
        @(negedge clk); en_req = 1'b0; e = cyc;
        chk("R2 busy on accept", busy, 1);
        chk("R2 card_en off on accept", card_en, 0);
        for (int k = 0; k < 200; k++) begin
            if (t_vcc < 0 && vcc_sel != 0) begin t_vcc = cyc; vcc_seen = vcc_sel; end
            if (t_en < 0 && glob_en) begin t_en = cyc; ce_at_en = card_en; end
            if (t_rr < 0 && card_rst) t_rr = cyc;
            if (t_rr >= 0 && t_rf < 0 && !card_rst) t_rf = cyc;
            if (vpp_sel != 0) vpp_bad = 1;
            if (powered) begin t_pw = cyc; if (!busy) t_bf = cyc; break; end
            en_req  = (k == inj);
            dis_req = (k == inj);
            if (k == inj) vcc_target = ~tgt;
            @(negedge clk);
            en_req = 1'b0; dis_req = 1'b0;
        end
        t_vcc -= e; t_en -= e; t_rr -= e; t_rf -= e; t_pw -= e; t_bf -= e;
        chk("R4 vcc time", t_vcc, dur(TCE) + dur(TZ) + dur(TF));
        chk("R10 latched vcc code", vcc_seen, int'(tgt));
        chk("R5 enable time", t_en, t_vcc + dur(TR));
        chk("R5 card_en with glob_en", ce_at_en, 1);
        chk("R6 reset start", t_rr, t_en + dur(TEN));
        chk("R6 reset width", t_rf - t_rr, dur(TRS));
        chk("R7 powered time", t_pw, t_rf + dur(TPO));
        chk("R7 busy falls with powered", t_bf, t_pw);
        chk("R10 vpp zero", vpp_bad, 0);
        chk("R9 vcc kept", int'(vcc_sel), int'(tgt));
    endtask

    task automatic power_down(input logic [1:0] tgt, input int inj);
        int e, t_z, t_off, ge_z;
        t_z = -1; t_off = -1; ge_z = 1;
        @(negedge clk); dis_req = 1'b1;
        @(negedge clk); dis_req = 1'b0; e = cyc;
        chk("R8 card_en cleared", card_en, 0);
        chk("R8 powered cleared", powered, 0);
        chk("R8 busy", busy, 1);
        chk("R8 vcc held", int'(vcc_sel), int'(tgt));
        for (int k = 0; k < 200; k++) begin
            if (t_z < 0 && vcc_sel == 0) begin t_z = cyc; ge_z = glob_en; end
            if (!busy) begin t_off = cyc; break; end
            en_req = (k == inj); dis_req = (k == inj);
            @(negedge clk);
            en_req = 1'b0; dis_req = 1'b0;
        end
        chk("R8 zero time", t_z - e, dur(TCE));
        chk("R8 glob_en off with vcc", ge_z, 0);
        chk("R8 off time", t_off - t_z, dur(TDN));
        chk("R9 stays off", int'(powered) + int'(vcc_sel), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int span;
        repeat (3) @(negedge clk);
        chk("R1 vcc", int'(vcc_sel), 0); chk("R1 vpp", int'(vpp_sel), 0);
        chk("R1 ce", card_en, 0); chk("R1 ge", glob_en, 0);
        chk("R1 rst", card_rst, 0); chk("R1 busy", busy, 0); chk("R1 powered", powered, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: invalid code is rejected
        vcc_target = 2'b11; en_req = 1'b1;
        @(negedge clk); en_req = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk("R3 no busy", busy, 0);
            chk("R3 vcc off", int'(vcc_sel), 0);
            @(negedge clk);
        end
        // R9: disable while off ignored
        dis_req = 1'b1; @(negedge clk); dis_req = 1'b0;
        chk("R9 disable while off", busy, 0);
        span = dur(TCE) + dur(TZ) + dur(TF) + dur(TR) + dur(TEN) + dur(TRS) + dur(TPO);
        // Sweep stray requests over every offset of both sequences
        for (int inj = 0; inj < span + 2; inj++) begin
            logic [1:0] t;
            t = (inj % 2 == 0) ? 2'b01 : 2'b10;
            power_up(t, inj);
            @(negedge clk); en_req = 1'b1; @(negedge clk); en_req = 1'b0;
            chk("R9 enable while powered", busy, 0);
            power_down(t, inj % (dur(TCE) + dur(TDN)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule